// File: doc/BRIEF.md
# Serial Receiver with Parked-Byte Overrun Handling

This block receives asynchronous serial frames (one start bit, eight data bits sent least significant bit first, one stop bit) on a single input line and delivers each completed byte to a host. The line is oversampled 16 times per bit, using a baud-tick enable supplied from outside. Before start-bit detection the line passes through a two-flop synchronizer.

Completed bytes go into a two-entry first-in first-out queue. When the queue is full, the next completed byte is not dropped. It waits in a parking slot that stands for the receive shift register. If a further start bit arrives while both the queue and the parking slot are occupied, an overrun is flagged and the parked byte is given up. The incoming byte then takes its place, so after any burst the host finds the two oldest bytes and the newest one.

The host side is a valid/ready stream. `rd_valid_o` stays high while the queue holds any byte. A byte is handed over on a rising clock edge where both `rd_valid_o` and `rd_ready_i` are high. The host may hold `rd_ready_i` low for as long as it likes. The receiver never stalls the line: back-pressure only fills the queue, then the parking slot, and beyond that it produces overruns.

Top module: `serial_rx_ovr`

## Requirements
- R1: The queue holds two bytes, and the byte on `rd_data_o` is always the oldest byte held; bytes leave in arrival order.
- R2: `rd_valid_o` is high exactly when at least one byte is queued. A transfer happens on a clock edge with `rd_valid_o` and `rd_ready_i` both high. `rd_ready_i` asserted while `rd_valid_o` is low has no effect on the queue or on any flag.
- R3: A byte that completes while the queue is full is parked, not discarded. The parking slot is occupied only while the queue is full.
- R4: An overrun is raised only when the queue is full, a byte is parked, and a new start bit is confirmed with no transfer in that cycle. The parked byte is then lost, and the byte that follows takes the parking slot.
- R5: `overrun_o` is sticky. It clears when the host takes the first surviving byte that completed after a loss, or on reset.
- R6: A transfer from a full queue moves the parked byte into the freed entry in the same edge. Six bytes received with no reads come back as the 1st, the 2nd and the 6th.
- R7: A start bit is accepted only if the line is still low at the 8th baud tick after the falling edge is seen. A shorter low pulse produces no byte. Data bits are sampled 16 ticks apart, least significant bit first.
- R8: A stop bit sampled low marks that byte with a frame error. `frame_err_o` is high while that byte is the one offered on `rd_data_o`, and the byte's data is still delivered.
- R9: After reset, `rd_valid_o`, `overrun_o` and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle enable, 16 pulses per bit time |
| rd_ready_i | input | 1 | Host accepts the offered byte |
| rd_valid_o | output | 1 | A byte is offered |
| rd_data_o | output | 8 | Oldest queued byte |
| frame_err_o | output | 1 | Offered byte had a low stop bit |
| overrun_o | output | 1 | Sticky overrun indication |

## Verification
A byte reaches the queue on the clock edge after its stop bit is sampled, which is the middle of the stop bit. `rd_valid_o` and the data are therefore due half a bit time before the serial driver finishes a frame, and the bench checks queue contents and flags only after a whole frame has been sent. An overrun is due one edge after the start bit is confirmed at mid-start, so the flag is checked once the following frame has completed. Reads are compared on the falling edge before the edge that performs the transfer, and flag checks that depend on a read wait until the scoreboard queue has shrunk and one more falling edge has passed.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= 1'b1;
        else        chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_i,
  output logic                 start_o,
  output logic                 done_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 ferr_o
);
  localparam int CW  = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam int MID = OSR / 2 - 1;

  rx_state_e            state_q;
  logic [CW-1:0]        cnt_q;
  logic [BW-1:0]        idx_q;
  logic [DATA_BITS-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      start_o <= 1'b0;
      done_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      if (tick_i) begin
        case (state_q)
          RX_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) state_q <= RX_START;
          end
          RX_START: begin
            if (cnt_q == CW'(MID)) begin
              cnt_q <= '0;
              idx_q <= '0;
              if (!rx_i) begin
                state_q <= RX_DATA;
                start_o <= 1'b1;
              end else begin
                state_q <= RX_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q   <= '0;
              shreg_q <= {rx_i, shreg_q[DATA_BITS-1:1]};
              if (idx_q == BW'(DATA_BITS - 1)) state_q <= RX_STOP;
              else                             idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q   <= '0;
              done_o  <= 1'b1;
              ferr_o  <= !rx_i;
              state_q <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign data_o = shreg_q;
endmodule

// File: rtl/serial_rx_store.sv
module serial_rx_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       done_i,
  input  logic [DW-1:0]              data_i,
  input  logic                       ferr_i,
  input  logic                       pop_i,
  output logic [DW-1:0]              head_data_o,
  output logic                       head_ferr_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       hold_vld_o,
  output logic                       overrun_o
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem_d [DEPTH];
  logic [DEPTH-1:0] mem_f, mem_t;
  logic [DW-1:0]   nxt_d [DEPTH];
  logic [DEPTH-1:0] nxt_f, nxt_t;
  logic [CNTW-1:0] cnt_q, cnt_after;

  logic [DW-1:0] hold_d_q;
  logic          hold_f_q, hold_t_q, hold_vld_q;
  logic          pend_tag_q, ovr_q;

  logic          move_hold, room, push_new, push, park, ovr_evt;
  logic [DW-1:0] in_d;
  logic          in_f, in_t;

  always_comb begin
    cnt_after = cnt_q - CNTW'(pop_i);
    move_hold = pop_i & hold_vld_q;
    room      = (cnt_after != CNTW'(DEPTH));
    push_new  = done_i & room & !move_hold;
    push      = move_hold | push_new;
    park      = done_i & !push_new;
    ovr_evt   = start_i & hold_vld_q & !pop_i;
    in_d      = move_hold ? hold_d_q : data_i;
    in_f      = move_hold ? hold_f_q : ferr_i;
    in_t      = move_hold ? hold_t_q : pend_tag_q;

    nxt_d = mem_d;
    nxt_f = mem_f;
    nxt_t = mem_t;
    if (pop_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        nxt_d[i] = mem_d[i+1];
        nxt_f[i] = mem_f[i+1];
        nxt_t[i] = mem_t[i+1];
      end
    end
    if (push) begin
      nxt_d[cnt_after] = in_d;
      nxt_f[cnt_after] = in_f;
      nxt_t[cnt_after] = in_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_d[i] <= '0;
      mem_f <= '0;
      mem_t <= '0;
      cnt_q <= '0;
    end else begin
      mem_d <= nxt_d;
      mem_f <= nxt_f;
      mem_t <= nxt_t;
      cnt_q <= cnt_after + CNTW'(push);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_d_q   <= '0;
      hold_f_q   <= 1'b0;
      hold_t_q   <= 1'b0;
      hold_vld_q <= 1'b0;
    end else begin
      if (move_hold || ovr_evt) hold_vld_q <= 1'b0;
      if (park) begin
        hold_vld_q <= 1'b1;
        hold_d_q   <= data_i;
        hold_f_q   <= ferr_i;
        hold_t_q   <= pend_tag_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_tag_q <= 1'b0;
      ovr_q      <= 1'b0;
    end else begin
      if (ovr_evt)     pend_tag_q <= 1'b1;
      else if (done_i) pend_tag_q <= 1'b0;
      if (ovr_evt)                 ovr_q <= 1'b1;
      else if (pop_i && mem_t[0])  ovr_q <= 1'b0;
    end
  end

  assign head_data_o = mem_d[0];
  assign head_ferr_o = mem_f[0];
  assign cnt_o       = cnt_q;
  assign hold_vld_o  = hold_vld_q;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/serial_rx_ovr.sv
module serial_rx_ovr #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int FIFO_DEPTH  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_i,
  input  logic                 baud_tick_i,
  input  logic                 rd_ready_i,
  output logic                 rd_valid_o,
  output logic [DATA_BITS-1:0] rd_data_o,
  output logic                 frame_err_o,
  output logic                 overrun_o
);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  logic                 rx_sync;
  logic                 start_seen, byte_done, byte_ferr, pop, hold_vld, head_ferr;
  logic [DATA_BITS-1:0] byte_data;
  logic [CNTW-1:0]      fifo_cnt;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rx_i),
    .q_o   (rx_sync)
  );

  serial_rx_framer #(.DATA_BITS(DATA_BITS), .OSR(OVERSAMPLE)) framer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (baud_tick_i),
    .rx_i    (rx_sync),
    .start_o (start_seen),
    .done_o  (byte_done),
    .data_o  (byte_data),
    .ferr_o  (byte_ferr)
  );

  assign pop = rd_valid_o & rd_ready_i;

  serial_rx_store #(.DW(DATA_BITS), .DEPTH(FIFO_DEPTH)) store_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_seen),
    .done_i      (byte_done),
    .data_i      (byte_data),
    .ferr_i      (byte_ferr),
    .pop_i       (pop),
    .head_data_o (rd_data_o),
    .head_ferr_o (head_ferr),
    .cnt_o       (fifo_cnt),
    .hold_vld_o  (hold_vld),
    .overrun_o   (overrun_o)
  );

  assign rd_valid_o  = (fifo_cnt != '0);
  assign frame_err_o = rd_valid_o & head_ferr;
endmodule

// File: rtl/serial_rx_ovr_chk.sv
module serial_rx_ovr_chk #(
  parameter int DEPTH = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rd_valid,
  input logic                       rd_ready,
  input logic                       overrun,
  input logic                       frame_err,
  input logic [$clog2(DEPTH+1)-1:0] fifo_cnt,
  input logic                       hold_vld,
  input logic                       byte_done,
  input logic                       start_seen
);
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= DEPTH);

  assert_idle_strobe_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && rd_ready && !byte_done) |=> (fifo_cnt == 0 && $stable(overrun)));

  assert_park_needs_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_vld |-> fifo_cnt == DEPTH);

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> ($past(hold_vld) && $past(start_seen) && $past(fifo_cnt) == DEPTH));

  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(rd_valid && rd_ready)) |=> overrun);

  assert_park_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && hold_vld) |=> (fifo_cnt == DEPTH && !hold_vld));

  assert_ferr_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> rd_valid);
endmodule

bind serial_rx_ovr serial_rx_ovr_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_valid   (rd_valid_o),
  .rd_ready   (rd_ready_i),
  .overrun    (overrun_o),
  .frame_err  (frame_err_o),
  .fifo_cnt   (fifo_cnt),
  .hold_vld   (hold_vld),
  .byte_done  (byte_done),
  .start_seen (start_seen)
);

// File: tb/serial_rx_ovr_tb_top.sv
`timescale 1ns/1ps
module serial_rx_ovr_tb_top;
  localparam int TICK_DIV = 4;
  localparam int BIT_CYC  = 16 * TICK_DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic       baud_tick_i = 1'b0;
  logic       rd_ready_i = 1'b0;
  logic       rd_valid_o, frame_err_o, overrun_o;
  logic [7:0] rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit reader_en = 1'b0;
  bit strobe_force = 1'b0;
  logic [8:0] exp_q[$];
  int   pend_n = 0;
  bit   m_hold_v = 1'b0;
  logic [8:0] m_hold = '0;

  always #2 clk = ~clk;

  serial_rx_ovr dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx_i),
    .baud_tick_i (baud_tick_i),
    .rd_ready_i  (rd_ready_i),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o),
    .frame_err_o (frame_err_o),
    .overrun_o   (overrun_o)
  );

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      baud_tick_i = (ph == TICK_DIV - 1);
      ph = (ph == TICK_DIV - 1) ? 0 : ph + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard model of what the host should eventually read
  task automatic model_add(input logic [7:0] b, input bit fe);
    if (reader_en) exp_q.push_back({fe, b});
    else if (pend_n < 2) begin exp_q.push_back({fe, b}); pend_n++; end
    else begin m_hold = {fe, b}; m_hold_v = 1'b1; end
  endtask

  task automatic start_reading();
    if (m_hold_v) exp_q.push_back(m_hold);
    m_hold_v = 1'b0;
    pend_n = 0;
    reader_en = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    model_add(b, !stop_ok);
    rx_i = 1'b0;
    repeat (BIT_CYC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_i = b[i];
      repeat (BIT_CYC) @(negedge clk);
    end
    if (stop_ok) begin
      rx_i = 1'b1;
      repeat (BIT_CYC) @(negedge clk);
    end else begin
      rx_i = 1'b0;
      repeat (BIT_CYC / 2 + 12) @(negedge clk);
      rx_i = 1'b1;
      repeat (2 * BIT_CYC) @(negedge clk);
    end
  endtask

  // monitor: compares the offered byte, then accepts it on the next edge
  initial begin : monitor
    forever begin
      @(negedge clk);
      if (!strobe_force) begin
        if (rd_ready_i) rd_ready_i = 1'b0;
        else if (reader_en && rd_valid_o) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R1", "unexpected byte", rd_data_o, 0);
          end else begin
            logic [8:0] e;
            e = exp_q.pop_front();
            chk(rd_data_o == e[7:0], "R1", "data order", rd_data_o, e[7:0]);
            chk(frame_err_o == e[8], "R8", "frame error", frame_err_o, e[8]);
          end
          rd_ready_i = 1'b1;
        end
      end
    end
  end

  task automatic drain();
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R9", "valid after reset", rd_valid_o, 0);
    chk(overrun_o == 1'b0, "R9", "overrun after reset", overrun_o, 0);
    chk(frame_err_o == 1'b0, "R9", "frame error after reset", frame_err_o, 0);
    rst_n = 1'b1;
    repeat (BIT_CYC) @(negedge clk);

    // R2: strobe while empty must not disturb the queue
    strobe_force = 1'b1;
    rd_ready_i = 1'b1;
    repeat (10) @(negedge clk);
    rd_ready_i = 1'b0;
    strobe_force = 1'b0;
    chk(rd_valid_o == 1'b0, "R2", "valid after idle strobe", rd_valid_o, 0);
    chk(overrun_o == 1'b0, "R2", "overrun after idle strobe", overrun_o, 0);
    send_byte(8'hA5, 1'b1);
    chk(rd_valid_o == 1'b1, "R2", "valid with one byte", rd_valid_o, 1);
    chk(rd_data_o == 8'hA5, "R2", "offered byte", rd_data_o, 8'hA5);
    start_reading();
    drain();
    chk(rd_valid_o == 1'b0, "R2", "valid after drain", rd_valid_o, 0);

    // R7: streaming patterns, LSB first
    send_byte(8'h00, 1'b1);
    send_byte(8'hFF, 1'b1);
    send_byte(8'h5A, 1'b1);
    send_byte(8'h81, 1'b1);
    send_byte(8'h3C, 1'b1);
    drain();

    // R7: short low pulse is not a start bit
    rx_i = 1'b0;
    repeat (5 * TICK_DIV) @(negedge clk);
    rx_i = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R7", "glitch produced no byte", rd_valid_o, 0);

    // R8: low stop bit marks that byte only
    send_byte(8'h77, 1'b0);
    send_byte(8'h12, 1'b1);
    drain();

    // R3: third byte parked, nothing lost, no overrun
    reader_en = 1'b0;
    send_byte(8'hA1, 1'b1);
    send_byte(8'hB2, 1'b1);
    send_byte(8'hC3, 1'b1);
    chk(overrun_o == 1'b0, "R3", "no overrun with parked byte", overrun_o, 0);
    chk(rd_data_o == 8'hA1, "R3", "head while parked", rd_data_o, 8'hA1);
    start_reading();
    drain();

    // R4/R6: six bytes, reads return 1st, 2nd, 6th
    reader_en = 1'b0;
    send_byte(8'h11, 1'b1);
    send_byte(8'h22, 1'b1);
    send_byte(8'h33, 1'b1);
    chk(overrun_o == 1'b0, "R4", "overrun before extra start", overrun_o, 0);
    send_byte(8'h44, 1'b1);
    chk(overrun_o == 1'b1, "R4", "overrun on extra start", overrun_o, 1);
    send_byte(8'h55, 1'b1);
    send_byte(8'h66, 1'b1);
    chk(overrun_o == 1'b1, "R5", "overrun held", overrun_o, 1);
    chk(exp_q.size() == 2 && m_hold == 9'h066, "R6", "model survivors", int'(m_hold), 9'h066);
    start_reading();
    wait (exp_q.size() == 1);
    @(negedge clk);
    chk(overrun_o == 1'b1, "R5", "overrun after older reads", overrun_o, 1);
    drain();
    chk(overrun_o == 1'b0, "R5", "overrun cleared by newest read", overrun_o, 0);
    chk(rd_valid_o == 1'b0, "R6", "empty after three reads", rd_valid_o, 0);

    // R9/R5: reset clears a pending overrun
    reader_en = 1'b0;
    send_byte(8'hE1, 1'b1);
    send_byte(8'hE2, 1'b1);
    send_byte(8'hE3, 1'b1);
    send_byte(8'hE4, 1'b1);
    chk(overrun_o == 1'b1, "R4", "overrun before reset", overrun_o, 1);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(overrun_o == 1'b0, "R9", "overrun cleared by reset", overrun_o, 0);
    chk(rd_valid_o == 1'b0, "R9", "queue emptied by reset", rd_valid_o, 0);
    exp_q.delete();
    pend_n = 0;
    m_hold_v = 1'b0;
    rst_n = 1'b1;
    reader_en = 1'b1;
    repeat (BIT_CYC) @(negedge clk);
    send_byte(8'h96, 1'b1);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule